// File: doc/BRIEF.md
# Serial Receive Path with Per-Character Line Status

This block takes an asynchronous serial line, recovers framed characters from it using an oversampling tick, and keeps the received characters in a small queue. Each stored character carries its own parity and framing flags. A register bus reads the characters out and shows the line status. The flags in the status byte always describe the character that the next buffer read will return. The overrun indication is a sticky flag kept apart from the queue.

A control register picks the storage mode. Queue mode keeps up to sixteen characters. Single-buffer mode keeps one character, and a new character overwrites it. The control register also selects optional parity checking with odd or even sense, and a multidrop mode. In multidrop mode the ninth received bit is stored as an address/data marker in place of a parity result. Software polls the status byte, reads characters from the buffer address, and reads the status byte again to acknowledge errors.

Top module: `serial_rx_status`

## Requirements
- R1: The line is sampled on `os_tick` pulses at 16 ticks per bit. A low level must still be low at the middle of the start bit, or it is ignored. Data bits arrive LSB first and are taken at their centre sample. A shorter low pulse stores nothing.
- R2: Status bit 0 (data ready) is 1 whenever at least one character is stored, and 0 once the store is empty.
- R3: Control bit 0 = 1 selects queue mode with 16 entries, returned in arrival order. A read at address 0 returns the oldest character and removes it. A read at address 0 with nothing stored returns 0 and changes nothing.
- R4: In queue mode, a character that completes while all 16 entries are full is discarded, and status bit 1 (overrun) is set.
- R5: With control bit 0 = 0, a single character is held. A new character that completes before the held one is read replaces it and sets overrun.
- R6: Control bit 1 enables a parity bit after the data. Control bit 2 selects odd (1) or even (0) parity. Status bit 2 is 1 when the oldest stored character had a parity mismatch.
- R7: Control bit 3 selects multidrop mode. The ninth bit is then stored as status bit 2 with no check (1 = address, 0 = data), and this takes precedence over control bit 1.
- R8: Status bit 3 is 1 when the oldest stored character had its stop bit sampled as 0. That character is still stored. After such a frame, the receiver waits for the line to return high before it looks for a new start bit.
- R9: A read at address 1 (status) clears overrun and the parity and framing flags of the oldest character only. Characters behind it keep their flags. An overrun in the same cycle as the read keeps overrun set.
- R10: A write at address 2 stores all 8 bits in the control register, readable at address 2. The write also discards every stored character and clears overrun. Address 3 reads as 0.
- R11: After reset, the control register, the status byte and the buffer read all return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit time |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 buffer, 1 status, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally while selected |

## Verification
A wrong count or pointer shows up as characters returned out of order, duplicated or missing. It also shows up as a data-ready bit that disagrees with the number of characters sent. This is visible on the first buffer read after the fault. A flag stored in the wrong entry, or cleared in the wrong entry, appears in the status byte after at most one pop. A desynchronised receiver FSM garbles the very next character, because every data bit lands in the wrong position.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DBITS = 8;

  localparam int CTL_QUEUE  = 0;
  localparam int CTL_PAR_EN = 1;
  localparam int CTL_ODD    = 2;
  localparam int CTL_MDROP  = 3;

  localparam logic [1:0] ADR_BUF  = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_CTL  = 2'd2;

  typedef struct packed {
    logic [SRX_DBITS-1:0] data;
    logic                 pe;
    logic                 fe;
  } srx_entry_t;

  // Flag stored in the parity slot: marker in multidrop, mismatch otherwise.
  function automatic logic srx_pe_flag(input logic [SRX_DBITS-1:0] d,
                                       input logic nin, input logic par_en,
                                       input logic odd, input logic mdrop);
    if (mdrop) return nin;
    if (par_en) return (^d) ^ nin ^ odd;
    return 1'b0;
  endfunction

  function automatic logic [7:0] srx_status_byte(input logic dr, input logic oe,
                                                 input logic pe, input logic fe);
    return {4'b0000, fe, pe, oe, dr};
  endfunction
endpackage

// File: rtl/srx_deser.sv
module srx_deser #(
  parameter int OVS   = 16,
  parameter int DBITS = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx_in,
  input  logic             ninth_en,
  output logic             done,
  output logic [DBITS-1:0] data,
  output logic             ninth,
  output logic             stop_bad
);
  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(DBITS + 1);
  localparam logic [TW-1:0] MID  = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] LAST = TW'(OVS - 1);
  localparam logic [BW-1:0] BTOP = BW'(DBITS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_NINTH, S_STOP, S_HOLD} st_t;

  logic [SYNC-1:0]  sr;
  logic             rx_s;
  st_t              st;
  logic [TW-1:0]    cnt;
  logic [BW-1:0]    bitn;
  logic [DBITS-1:0] shreg;
  logic             ninth_r;
  logic             centre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[SYNC-2:0], rx_in};
  end
  assign rx_s   = sr[SYNC-1];
  assign centre = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      ninth_r  <= 1'b0;
      done     <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (tick && !rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (cnt == MID) begin
              st      <= rx_s ? S_IDLE : S_DATA;
              cnt     <= '0;
              bitn    <= '0;
              ninth_r <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (centre) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[DBITS-1:1]};
            if (bitn == BTOP) st <= ninth_en ? S_NINTH : S_STOP;
            else              bitn <= bitn + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_NINTH: begin
          if (centre) begin
            cnt     <= '0;
            ninth_r <= rx_s;
            st      <= S_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (centre) begin
            cnt      <= '0;
            done     <= 1'b1;
            stop_bad <= !rx_s;
            st       <= rx_s ? S_IDLE : S_HOLD;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (rx_s) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign data  = shreg;
  assign ninth = ninth_r;
endmodule

// File: rtl/srx_store.sv
module srx_store
  import srx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        queue_en,
  input  logic        push,
  input  srx_entry_t  push_ent,
  input  logic        pop_req,
  input  logic        clr_head,
  input  logic        flush,
  output srx_entry_t  head,
  output logic [CW-1:0] count,
  output logic        ovr_evt,
  output logic        pop_evt
);
  srx_entry_t     mem [DEPTH];
  logic [AW-1:0]  rd_ptr, wr_ptr;
  logic [CW-1:0]  cap;
  logic           full_eff, wr_ok, ovw, has;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap      = queue_en ? CW'(DEPTH) : CW'(1);
  assign has      = (count != '0);
  assign pop_evt  = pop_req && has;
  assign full_eff = (count >= cap) && !pop_evt;
  assign wr_ok    = push && !full_eff && !flush;
  assign ovr_evt  = push && full_eff && !flush;
  assign ovw      = ovr_evt && !queue_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok)   wr_ptr <= nxt(wr_ptr);
      if (pop_evt) rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(wr_ok) - CW'(pop_evt);
    end
  end

  always_ff @(posedge clk) begin
    if (clr_head && has && !ovw) begin
      mem[rd_ptr].pe <= 1'b0;
      mem[rd_ptr].fe <= 1'b0;
    end
    if (wr_ok)    mem[wr_ptr] <= push_ent;
    else if (ovw) mem[rd_ptr] <= push_ent;
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  input  srx_entry_t    head,
  input  logic [CW-1:0] count,
  input  logic          ovr_evt,
  output logic [7:0]    ctl,
  output logic          pop_req,
  output logic          stat_rd,
  output logic          flush,
  output logic          oe,
  output logic          dr,
  output logic [7:0]    bus_rdata
);
  logic rd;

  assign rd      = bus_sel && !bus_wr;
  assign pop_req = rd && (bus_addr == ADR_BUF);
  assign stat_rd = rd && (bus_addr == ADR_STAT);
  assign flush   = bus_sel && bus_wr && (bus_addr == ADR_CTL);
  assign dr      = (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      oe  <= 1'b0;
    end else begin
      if (flush) ctl <= bus_wdata;
      if (ovr_evt)              oe <= 1'b1;
      else if (stat_rd || flush) oe <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADR_BUF:  bus_rdata = dr ? head.data : 8'h00;
      ADR_STAT: bus_rdata = srx_status_byte(dr, oe, dr & head.pe, dr & head.fe);
      ADR_CTL:  bus_rdata = ctl;
      default:  bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import srx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       os_tick,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]           ctl_q;
  logic                 queue_en, ninth_en;
  logic                 push_evt, ovr_evt, pop_evt, pop_req, stat_rd, flush_evt;
  logic                 data_rdy, oe_flag;
  logic [SRX_DBITS-1:0] rx_data;
  logic                 rx_ninth, rx_stop_bad;
  logic [CW-1:0]        count;
  srx_entry_t           push_ent, head;

  assign queue_en = ctl_q[CTL_QUEUE];
  assign ninth_en = ctl_q[CTL_PAR_EN] | ctl_q[CTL_MDROP];

  srx_deser #(.OVS(OVS), .DBITS(SRX_DBITS), .SYNC(2)) u_deser (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_in(rx_line),
    .ninth_en(ninth_en), .done(push_evt), .data(rx_data),
    .ninth(rx_ninth), .stop_bad(rx_stop_bad)
  );

  assign push_ent.data = rx_data;
  assign push_ent.pe   = srx_pe_flag(rx_data, rx_ninth, ctl_q[CTL_PAR_EN],
                                     ctl_q[CTL_ODD], ctl_q[CTL_MDROP]);
  assign push_ent.fe   = rx_stop_bad;

  srx_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .queue_en(queue_en), .push(push_evt),
    .push_ent(push_ent), .pop_req(pop_req), .clr_head(stat_rd),
    .flush(flush_evt), .head(head), .count(count), .ovr_evt(ovr_evt),
    .pop_evt(pop_evt)
  );

  srx_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .head(head), .count(count),
    .ovr_evt(ovr_evt), .ctl(ctl_q), .pop_req(pop_req), .stat_rd(stat_rd),
    .flush(flush_evt), .oe(oe_flag), .dr(data_rdy), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          queue_en,
  input logic          push_evt,
  input logic          ovr_evt,
  input logic          pop_evt,
  input logic          stat_rd,
  input logic          flush_evt,
  input logic [CW-1:0] count,
  input logic          data_rdy,
  input logic          oe_flag
);
  AST_DR_RISES_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !flush_evt) |=> data_rdy); // R2
  AST_DR_DROPS_ON_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && count == CW'(1) && !push_evt && !flush_evt) |=> !data_rdy); // R2
  AST_COUNT_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (queue_en ? CW'(DEPTH) : CW'(1))); // R3
  AST_OVR_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && queue_en && !pop_evt) |=> $stable(count)); // R4
  AST_OVR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> oe_flag); // R4
  AST_SINGLE_BUF_HOLDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !queue_en) |=> count == CW'(1)); // R5
  AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovr_evt) |=> !oe_flag); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (count == '0 && !oe_flag)); // R10
endmodule

bind serial_rx_status serial_rx_status_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .queue_en(queue_en), .push_evt(push_evt),
  .ovr_evt(ovr_evt), .pop_evt(pop_evt), .stat_rd(stat_rd),
  .flush_evt(flush_evt), .count(count), .data_rdy(data_rdy), .oe_flag(oe_flag)
);

// File: tb/serial_rx_status_bench.sv
`timescale 1ns/1ps
module serial_rx_status_bench;
  localparam int BITCLK = 32; // 16 ticks per bit, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // bench model
  logic [9:0] mq [16];
  int         mhead = 0, mcnt = 0;
  logic       moe = 1'b0;
  logic [7:0] mctl = 8'h00;

  serial_rx_status u_serial_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  function automatic logic exp_flag(input logic [7:0] d, input logic nb);
    if (mctl[3]) return nb;
    if (mctl[1]) return ((($countones(d) + int'(nb)) % 2) == 1) != mctl[2];
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_status();
    if (mcnt == 0) return {6'b0, moe, 1'b0};
    return {4'b0, mq[mhead][0], mq[mhead][1], moe, 1'b1};
  endfunction

  task automatic model_push(input logic [7:0] d, input logic nb, input logic fe);
    int cap = mctl[0] ? 16 : 1;
    logic [9:0] e = {d, exp_flag(d, nb), fe};
    if (mcnt < cap) begin
      mq[(mhead + mcnt) % 16] = e;
      mcnt++;
    end else begin
      moe = 1'b1;
      if (!mctl[0]) mq[mhead] = e;
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    mctl = v; mcnt = 0; mhead = 0; moe = 1'b0;
  endtask

  task automatic rd_stat(input string tag);
    logic [7:0] v;
    bus_read(2'd1, v);
    check(tag, v, exp_status());
    moe = 1'b0;
    if (mcnt != 0) mq[mhead][1:0] = 2'b00;
  endtask

  task automatic rd_buf(input string tag);
    logic [7:0] v;
    bus_read(2'd0, v);
    if (mcnt != 0) begin
      check(tag, v, mq[mhead][9:2]);
      mhead = (mhead + 1) % 16;
      mcnt--;
    end else begin
      check(tag, v, 8'h00);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic nb, input logic stopv);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (mctl[1] || mctl[3]) begin
      rx_line = nb;
      repeat (BITCLK) @(negedge clk);
    end
    rx_line = stopv;
    repeat (BITCLK) @(negedge clk);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    model_push(d, nb, !stopv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: reset state
    bus_read(2'd2, v); check("R11 ctl", v, 8'h00);
    bus_read(2'd1, v); check("R11 stat", v, 8'h00);
    bus_read(2'd0, v); check("R11 buf", v, 8'h00);
    bus_read(2'd3, v); check("R10 addr3", v, 8'h00);

    // R1/R2/R3: one character in queue mode
    wr_ctl(8'h01);
    bus_read(2'd2, v); check("R10 ctl readback", v, 8'h01);
    send_frame(8'hA5, 1'b0, 1'b1);
    rd_stat("R2 ready set");
    rd_buf("R1 data A5");
    rd_stat("R2 ready clear");
    rd_buf("R3 empty read");

    // R1: glitch shorter than half a bit
    @(negedge clk); rx_line = 1'b0;
    repeat (8) @(negedge clk); rx_line = 1'b1;
    repeat (150) @(negedge clk);
    rd_stat("R1 glitch ignored");
    send_frame(8'h3C, 1'b0, 1'b1);
    rd_buf("R1 after glitch");

    // R3/R4: fill sixteen, one more overruns
    for (int i = 0; i < 17; i++) send_frame(8'(8'h10 + i * 7), 1'b0, 1'b1);
    rd_stat("R4 overrun flag");
    for (int i = 0; i < 16; i++) rd_buf("R3 order");
    rd_stat("R4 empty after drain");

    // R5: single buffer replaced
    wr_ctl(8'h00);
    send_frame(8'h11, 1'b0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b1);
    rd_stat("R5 overrun single");
    rd_buf("R5 newest kept");
    rd_stat("R5 empty");

    // R6: odd parity
    wr_ctl(8'h07);
    send_frame(8'h03, 1'b1, 1'b1);
    send_frame(8'h03, 1'b0, 1'b1);
    rd_stat("R6 parity good");
    rd_buf("R6 data");
    rd_stat("R6 parity bad");
    rd_buf("R6 data2");

    // R8/R9: framing flags per entry
    wr_ctl(8'h01);
    send_frame(8'h81, 1'b0, 1'b0);
    send_frame(8'h42, 1'b0, 1'b0);
    rd_stat("R8 framing head");
    rd_stat("R9 head cleared");
    rd_buf("R8 data kept");
    rd_stat("R9 next keeps flag");
    rd_buf("R8 data2");

    // R7: multidrop marker overrides odd parity
    wr_ctl(8'h0F);
    send_frame(8'h55, 1'b1, 1'b1);
    send_frame(8'h55, 1'b0, 1'b1);
    rd_stat("R7 address marker");
    rd_buf("R7 data");
    rd_stat("R7 data marker");
    rd_buf("R7 data2");

    // R10: control write flushes
    wr_ctl(8'h01);
    send_frame(8'h99, 1'b0, 1'b1);
    wr_ctl(8'hF1);
    rd_stat("R10 flushed");
    bus_read(2'd2, v); check("R10 ctl all bits", v, 8'hF1);

    // random phase
    for (int n = 0; n < 60; n++) begin
      if (n % 12 == 0) begin
        logic [7:0] modes [6] = '{8'h01, 8'h00, 8'h03, 8'h07, 8'h09, 8'h0B};
        logic [7:0] c = {4'($urandom), modes[$urandom % 6][3:0]};
        wr_ctl(c);
        bus_read(2'd2, v); check("R10 random ctl", v, c);
      end
      send_frame(8'($urandom), 1'($urandom), ($urandom % 8) != 0);
      case ($urandom % 4)
        1: rd_stat("R9 random stat");
        2: rd_buf("R3 random buf");
        3: begin rd_stat("R6 random stat"); rd_buf("R5 random buf"); end
        default: ;
      endcase
    end
    for (int i = 0; i < 17; i++) begin
      rd_stat("R8 drain stat");
      rd_buf("R3 drain buf");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule